// File: doc/BRIEF.md
# Three-Channel Match Timer with Deferred Restart

This block is a register-mapped timer holding three independent up-counters. Each counter picks its count clock from three tick-enable inputs: a fast tick, a 32768 Hz tick and a 1 kHz tick, all sampled in the bus clock domain. Each counter compares its live count against one match value. A match sets that counter's status bit, and the counter's interrupt line follows that status bit through an enable mask. Software can request two operations that complete on a later count tick rather than at once: a restart, which zeroes the counter and installs a new match value, and a snapshot, which captures the live count into a readable register.

Every counter runs a channel state machine with three states. In `CH_IDLE` the counter is stopped. In `CH_RUN` it counts. In `CH_DRAIN` its enable has been cleared but it keeps counting for a fixed number of selected ticks. The transitions are: `CH_IDLE -> CH_RUN` when the enable bit is set, which also installs the match value. `CH_RUN -> CH_DRAIN` when the enable bit is cleared. `CH_DRAIN -> CH_RUN` when the enable bit is set again. `CH_DRAIN -> CH_IDLE` on the last drain tick. Each restart request and each snapshot request has its own two-state machine. `RQ_IDLE -> RQ_WAIT` on an accepted request. `RQ_WAIT -> RQ_IDLE` on the second selected tick, which is the tick that performs the operation.

The bus is a simple word-addressed port: address, write enable, write data, and combinational read data.

Top module: `mtimer_top`

## Requirements
- R1: After reset, every register reads 0: clock select at address 0, enable at 1, restart-pending at 2, mode at 3, status at 4, interrupt enable at 5, the match values at 8+n, the snapshots at 12+n and the live counts at 16+n. All `irq` bits are 0.
- R2: Each counter counts only the tick input named by its 2-bit source code. Counter 0: code 0 selects fast and code 1 selects 32768 Hz. Counter 1: code 0 selects fast, code 1 selects 32768 Hz and code 2 selects 1 kHz. Counter 2: code 0 selects fast, code 1 selects 1 kHz and code 2 selects 32768 Hz. Any other code selects no tick.
- R3: Bit n of the enable register (address 1) runs counter n. After the bit is cleared, the counter counts exactly two more selected ticks and then holds its value.
- R4: If the enable bit is set again while those two drain ticks are still pending, the counter returns to running and counts every following tick.
- R5: Status bit n (address 4) sets on the tick at which counter n's count becomes equal to its active match value. With a match value of D-1, status sets on the D-th selected tick, counting the restart tick as the first.
- R6: `irq[n]` is high while status bit n and interrupt-enable bit n (address 5) are both 1. Writing 1 to bit n of the clear register (address 6) clears status bit n. If a match occurs in the same cycle, the match wins.
- R7: Writing 1 to bit n of address 2 arms a restart, and bit n reads back as 1 while the restart is pending. On the second selected tick after the write, the counter is zeroed and the pending bit clears. A write made while the restart is pending is ignored.
- R8: Writing a match register (address 8+n) does not change the active comparison value. The new value takes effect at the next restart, or when the counter is enabled from the stopped state.
- R9: Writing 1 to bit 0 of address 12+n requests a snapshot. On the second selected tick after the write, the count after that tick is copied into the snapshot. Until then, the same address returns the previous snapshot.
- R10: The mode register (address 3) holds three read/write bits. Counters run freely and keep counting past a match.
- R11: In the clock-select register (address 0), counter 0 uses bits 1:0, counter 1 uses bits 3:2 and counter 2 uses bits 6:5. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| tick_fast | input | 1 | Fast count-clock tick enable |
| tick_32k | input | 1 | 32768 Hz tick enable |
| tick_1k | input | 1 | 1 kHz tick enable |
| irq | output | 3 | Per-counter interrupt |

## Verification
Clock selection is tried with directed sequences of single-source ticks, followed by a random run. The random run draws a source code per counter, including the unused code, and a mix of tick inputs per cycle. The counts then separate each counter's own code table from the tables of its neighbours. Enable is tested two ways: disabled with no interruption, and disabled and then re-enabled during the drain. These two cases tell a drain of exactly two ticks apart from an immediate stop and from a lost re-enable. The match and restart sequences check the following:
- that restart is delayed by exactly one tick;
- that a match value of D-1 sets status on the D-th tick;
- that a match-register write stays inactive until a restart;
- that a second restart request made while one is pending is ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_CNT = 3;
    localparam int BUS_AW  = 5;
    localparam int BUS_DW  = 32;

    localparam logic [BUS_AW-1:0] RA_CLKSEL  = 5'd0;
    localparam logic [BUS_AW-1:0] RA_ENABLE  = 5'd1;
    localparam logic [BUS_AW-1:0] RA_RESTART = 5'd2;
    localparam logic [BUS_AW-1:0] RA_MODE    = 5'd3;
    localparam logic [BUS_AW-1:0] RA_STATUS  = 5'd4;
    localparam logic [BUS_AW-1:0] RA_IRQEN   = 5'd5;
    localparam logic [BUS_AW-1:0] RA_CLEAR   = 5'd6;
    localparam logic [BUS_AW-1:0] RA_MATCH   = 5'd8;
    localparam logic [BUS_AW-1:0] RA_SNAP    = 5'd12;
    localparam logic [BUS_AW-1:0] RA_COUNT   = 5'd16;

    // bits that exist in the clock-select register
    localparam logic [BUS_DW-1:0] CLKSEL_MASK = 32'h0000_006F;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_WAIT = 1'b1
    } rq_state_e;

    // lsb of each counter's source field
    function automatic int src_lsb(input int idx);
        return (idx == 0) ? 0 : (idx == 1) ? 2 : 5;
    endfunction
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter int IDX = 0
) (
    input  logic [1:0] code,
    input  logic       tick_fast,
    input  logic       tick_32k,
    input  logic       tick_1k,
    output logic       tick
);
    generate
        if (IDX == 0) begin : g_sel0
            always_comb begin
                case (code)
                    2'd0:    tick = tick_fast;
                    2'd1:    tick = tick_32k;
                    default: tick = 1'b0;
                endcase
            end
        end else if (IDX == 1) begin : g_sel1
            always_comb begin
                case (code)
                    2'd0:    tick = tick_fast;
                    2'd1:    tick = tick_32k;
                    2'd2:    tick = tick_1k;
                    default: tick = 1'b0;
                endcase
            end
        end else begin : g_sel2
            always_comb begin
                case (code)
                    2'd0:    tick = tick_fast;
                    2'd1:    tick = tick_1k;
                    2'd2:    tick = tick_32k;
                    default: tick = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_req.sv
module tmr_req
    import tmr_pkg::*;
#(
    parameter int REQ_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tick,
    output logic busy,
    output logic fire
);
    localparam int TW = (REQ_TICKS > 1) ? $clog2(REQ_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(REQ_TICKS - 1);

    rq_state_e      st, st_n;
    logic [TW-1:0]  tc, tc_n;

    always_comb begin
        st_n = st;
        tc_n = tc;
        unique case (st)
            RQ_IDLE: begin
                if (req) begin
                    st_n = RQ_WAIT;
                    tc_n = '0;
                end
            end
            RQ_WAIT: begin
                if (tick) begin
                    if (tc == LAST) st_n = RQ_IDLE;
                    else            tc_n = tc + 1'b1;
                end
            end
            default: st_n = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RQ_IDLE;
            tc <= '0;
        end else begin
            st <= st_n;
            tc <= tc_n;
        end
    end

    always_comb begin
        busy = (st == RQ_WAIT);
        fire = (st == RQ_WAIT) && tick && (tc == LAST);
    end

    // R7: an accepted request is pending on the next cycle
    a_r7_request_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (req && st == RQ_IDLE) |=> busy);
    // R7: completion leaves nothing pending
    a_r7_fire_ends: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !busy);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int STOP_TICKS = 2,
    parameter int REQ_TICKS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] match_val,
    input  logic             restart_req,
    input  logic             snap_req,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snap,
    output logic             status,
    output logic             restart_busy,
    output logic             snap_busy
);
    localparam int DW = (STOP_TICKS > 1) ? $clog2(STOP_TICKS) : 1;
    localparam logic [DW-1:0] DLAST = DW'(STOP_TICKS - 1);

    ch_state_e        st, st_n;
    logic [DW-1:0]    dcnt;
    logic [CNT_W-1:0] act_match, cmp, cnt_n;
    logic             counting, hit, rs_fire, sn_fire;

    tmr_req #(.REQ_TICKS(REQ_TICKS)) u_restart (
        .clk(clk), .rst_n(rst_n), .req(restart_req), .tick(tick),
        .busy(restart_busy), .fire(rs_fire)
    );

    tmr_req #(.REQ_TICKS(REQ_TICKS)) u_snap (
        .clk(clk), .rst_n(rst_n), .req(snap_req), .tick(tick),
        .busy(snap_busy), .fire(sn_fire)
    );

    // channel state machine: next state
    always_comb begin
        st_n = st;
        unique case (st)
            CH_IDLE:  if (en) st_n = CH_RUN;
            CH_RUN:   if (!en) st_n = CH_DRAIN;
            CH_DRAIN: begin
                if (en)                          st_n = CH_RUN;
                else if (tick && dcnt == DLAST)  st_n = CH_IDLE;
            end
            default:  st_n = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= CH_IDLE;
            dcnt <= '0;
        end else begin
            st <= st_n;
            if (st != CH_DRAIN) dcnt <= '0;
            else if (tick)      dcnt <= dcnt + 1'b1;
        end
    end

    // counting datapath
    always_comb begin
        counting = (st != CH_IDLE) && tick;
        cmp      = rs_fire ? match_val : act_match;
        if (rs_fire)       cnt_n = '0;
        else if (counting) cnt_n = count + 1'b1;
        else               cnt_n = count;
        hit = (rs_fire || counting) && (cnt_n == cmp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            act_match <= '0;
            status    <= 1'b0;
            snap      <= '0;
        end else begin
            count <= cnt_n;
            if (rs_fire || (st == CH_IDLE && en)) act_match <= match_val;
            if (hit)      status <= 1'b1;
            else if (clr) status <= 1'b0;
            if (sn_fire)  snap <= cnt_n;
        end
    end

    // R3: a stopped counter holds unless a restart lands
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_IDLE && !rs_fire) |=> (count == $past(count)));
    // R5: a match leaves status set
    a_r5_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status);
    // R6: clear without a concurrent match drops status
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !status);
    // R7: restart completion zeroes the count
    a_r7_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        rs_fire |=> (count == '0));
    // R9: captured value equals the live count it was taken from
    a_r9_snap_equals_live: assert property (@(posedge clk) disable iff (!rst_n)
        sn_fire |=> (snap == count));
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int STOP_TICKS = 2,
    parameter int REQ_TICKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic              wr_en,
    input  logic [BUS_DW-1:0] wr_data,
    output logic [BUS_DW-1:0] rd_data,
    input  logic              tick_fast,
    input  logic              tick_32k,
    input  logic              tick_1k,
    output logic [NUM_CNT-1:0] irq
);
    logic [BUS_DW-1:0]  clksel_q;
    logic [NUM_CNT-1:0] enable_q, mode_q, irqen_q;
    logic [CNT_W-1:0]   match_q [NUM_CNT];

    logic [CNT_W-1:0]   cnt_w  [NUM_CNT];
    logic [CNT_W-1:0]   snap_w [NUM_CNT];
    logic [NUM_CNT-1:0] status_w, rs_busy, sn_busy;
    logic [NUM_CNT-1:0] rs_req, sn_req, clr_w, tick_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clksel_q <= '0;
            enable_q <= '0;
            mode_q   <= '0;
            irqen_q  <= '0;
            for (int i = 0; i < NUM_CNT; i++) match_q[i] <= '0;
        end else if (wr_en) begin
            if (addr == RA_CLKSEL) clksel_q <= wr_data & CLKSEL_MASK;
            if (addr == RA_ENABLE) enable_q <= wr_data[NUM_CNT-1:0];
            if (addr == RA_MODE)   mode_q   <= wr_data[NUM_CNT-1:0];
            if (addr == RA_IRQEN)  irqen_q  <= wr_data[NUM_CNT-1:0];
            for (int i = 0; i < NUM_CNT; i++)
                if (addr == RA_MATCH + BUS_AW'(i)) match_q[i] <= wr_data[CNT_W-1:0];
        end
    end

    generate
        for (genvar g = 0; g < NUM_CNT; g++) begin : g_ch
            localparam int LSB = src_lsb(g);

            tmr_tick_sel #(.IDX(g)) u_sel (
                .code(clksel_q[LSB +: 2]),
                .tick_fast(tick_fast),
                .tick_32k(tick_32k),
                .tick_1k(tick_1k),
                .tick(tick_w[g])
            );

            assign rs_req[g] = wr_en && (addr == RA_RESTART) && wr_data[g];
            assign sn_req[g] = wr_en && (addr == RA_SNAP + BUS_AW'(g)) && wr_data[0];
            assign clr_w[g]  = wr_en && (addr == RA_CLEAR) && wr_data[g];

            tmr_chan #(
                .CNT_W(CNT_W), .STOP_TICKS(STOP_TICKS), .REQ_TICKS(REQ_TICKS)
            ) u_chan (
                .clk(clk), .rst_n(rst_n), .tick(tick_w[g]), .en(enable_q[g]),
                .match_val(match_q[g]), .restart_req(rs_req[g]),
                .snap_req(sn_req[g]), .clr(clr_w[g]),
                .count(cnt_w[g]), .snap(snap_w[g]), .status(status_w[g]),
                .restart_busy(rs_busy[g]), .snap_busy(sn_busy[g])
            );

            assign irq[g] = status_w[g] & irqen_q[g];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        unique case (addr)
            RA_CLKSEL:  rd_data = clksel_q;
            RA_ENABLE:  rd_data = BUS_DW'(enable_q);
            RA_RESTART: rd_data = BUS_DW'(rs_busy);
            RA_MODE:    rd_data = BUS_DW'(mode_q);
            RA_STATUS:  rd_data = BUS_DW'(status_w);
            RA_IRQEN:   rd_data = BUS_DW'(irqen_q);
            default: begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (addr == RA_MATCH + BUS_AW'(i)) rd_data = BUS_DW'(match_q[i]);
                    if (addr == RA_SNAP  + BUS_AW'(i)) rd_data = BUS_DW'(snap_w[i]);
                    if (addr == RA_COUNT + BUS_AW'(i)) rd_data = BUS_DW'(cnt_w[i]);
                end
            end
        endcase
    end

    // R6: a raised interrupt needs its enable bit
    a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irqen_q == '0) |-> (irq == '0));
endmodule

// File: tb/sim_mtimer_top.sv
module sim_mtimer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick_fast = 1'b0, tick_32k = 1'b0, tick_1k = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mtimer_top u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_fast(tick_fast), .tick_32k(tick_32k),
        .tick_1k(tick_1k), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic rdchk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic tk(input bit f, input bit s, input bit k);
        @(negedge clk);
        tick_fast = f; tick_32k = s; tick_1k = k;
        @(negedge clk);
        tick_fast = 1'b0; tick_32k = 1'b0; tick_1k = 1'b0;
    endtask

    task automatic tkn(input int n);
        for (int i = 0; i < n; i++) tk(1'b1, 1'b0, 1'b0);
    endtask

    // expected source selection per counter (R2 code tables)
    function automatic bit sel(input int n, input logic [1:0] code,
                               input bit f, input bit s, input bit k);
        if (n == 0) return (code == 2'd0) ? f : (code == 2'd1) ? s : 1'b0;
        if (n == 1) return (code == 2'd0) ? f : (code == 2'd1) ? s : (code == 2'd2) ? k : 1'b0;
        return (code == 2'd0) ? f : (code == 2'd1) ? k : (code == 2'd2) ? s : 1'b0;
    endfunction

    function automatic logic [31:0] clksel_word(input logic [1:0] c0, input logic [1:0] c1,
                                                input logic [1:0] c2);
        return (32'(c2) << 5) | (32'(c1) << 2) | 32'(c0);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v1;
        logic [31:0] expc [3];
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 7; a++) rdchk("R1", 5'(a), 32'h0);
        for (int n = 0; n < 3; n++) begin
            rdchk("R1", 5'(8 + n), 32'h0);
            rdchk("R1", 5'(12 + n), 32'h0);
            rdchk("R1", 5'(16 + n), 32'h0);
        end
        chk("R1 irq", 32'(irq), 32'h0);

        // R11: field positions
        wr(5'd0, 32'hFFFF_FFFF);
        rdchk("R11", 5'd0, 32'h0000_006F);
        wr(5'd0, 32'h0);

        // R2 directed
        wr(5'd1, 32'h7);
        tkn(3);
        for (int n = 0; n < 3; n++) rdchk("R2 fast", 5'(16 + n), 32'd3);
        wr(5'd0, clksel_word(2'd1, 2'd2, 2'd2));
        tk(1'b0, 1'b1, 1'b0);
        tk(1'b0, 1'b1, 1'b0);
        rdchk("R2 c0 32k", 5'd16, 32'd5);
        rdchk("R2 c1 1k-code", 5'd17, 32'd3);
        rdchk("R2 c2 32k", 5'd18, 32'd5);
        for (int i = 0; i < 3; i++) tk(1'b0, 1'b0, 1'b1);
        tk(1'b1, 1'b0, 1'b0);
        rdchk("R2 c0", 5'd16, 32'd5);
        rdchk("R2 c1 1k", 5'd17, 32'd6);
        rdchk("R2 c2", 5'd18, 32'd5);
        expc[0] = 32'd5; expc[1] = 32'd6; expc[2] = 32'd5;

        // R2 random: source codes and tick mixes
        for (int it = 0; it < 40; it++) begin
            logic [1:0] cd [3];
            for (int n = 0; n < 3; n++) cd[n] = 2'($urandom % 4);
            wr(5'd0, clksel_word(cd[0], cd[1], cd[2]));
            for (int t = 0; t < 3; t++) begin
                bit f, s, k;
                f = 1'($urandom % 2);
                s = 1'($urandom % 2);
                k = 1'($urandom % 2);
                tk(f, s, k);
                for (int n = 0; n < 3; n++)
                    if (sel(n, cd[n], f, s, k)) expc[n] = expc[n] + 1;
            end
            for (int n = 0; n < 3; n++) rdchk("R2 random", 5'(16 + n), expc[n]);
        end
        wr(5'd0, 32'h0);

        // R3: disable drains exactly two ticks
        rd(5'd16, v);
        rd(5'd17, v1);
        wr(5'd1, 32'h6);
        tkn(5);
        rdchk("R3 drained", 5'd16, v + 32'd2);
        rdchk("R3 running", 5'd17, v1 + 32'd5);

        // R4: re-enable during drain
        rd(5'd17, v1);
        wr(5'd1, 32'h4);
        tkn(1);
        wr(5'd1, 32'h6);
        tkn(5);
        rdchk("R4", 5'd17, v1 + 32'd6);

        // R7 / R5 / R6 / R10 on counter 0, match D-1 = 4
        wr(5'd8, 32'd4);
        wr(5'd1, 32'h7);
        rd(5'd16, v);
        wr(5'd2, 32'h1);
        rdchk("R7 pending", 5'd2, 32'h1);
        tkn(1);
        rdchk("R7 still pending", 5'd2, 32'h1);
        rdchk("R7 not yet zero", 5'd16, v + 32'd1);
        tkn(1);
        rdchk("R7 cleared", 5'd2, 32'h0);
        rdchk("R7 zeroed", 5'd16, 32'd0);
        wr(5'd6, 32'h7);
        tkn(3);
        rd(5'd4, v);
        chk("R5 before D", v & 32'h1, 32'h0);
        tkn(1);
        rd(5'd4, v);
        chk("R5 at D", v & 32'h1, 32'h1);
        chk("R6 masked", 32'(irq[0]), 32'h0);
        wr(5'd5, 32'h1);
        #1 chk("R6 irq", 32'(irq[0]), 32'h1);
        tkn(2);
        rdchk("R10 free-run", 5'd16, 32'd6);
        wr(5'd6, 32'h1);
        rd(5'd4, v);
        chk("R6 clear", v & 32'h1, 32'h0);
        chk("R6 irq drop", 32'(irq[0]), 32'h0);

        // R8 on counter 1: match write deferred until restart
        rd(5'd17, v1);
        wr(5'd9, v1 + 32'd1);
        wr(5'd6, 32'h7);
        tkn(1);
        rdchk("R8 count", 5'd17, v1 + 32'd1);
        rd(5'd4, v);
        chk("R8 not applied", v & 32'h2, 32'h0);
        wr(5'd9, 32'd1);
        wr(5'd2, 32'h2);
        tkn(2);
        rdchk("R8 restart", 5'd17, 32'd0);
        tkn(1);
        rd(5'd4, v);
        chk("R8 applied", v & 32'h2, 32'h2);

        // R7: second request while pending is ignored (counter 2)
        wr(5'd2, 32'h4);
        tkn(1);
        wr(5'd2, 32'h4);
        tkn(1);
        rdchk("R7 ignore pending", 5'd2, 32'h0);
        rdchk("R7 ignore count", 5'd18, 32'd0);

        // R9 snapshot on counter 2
        tkn(3);
        wr(5'd14, 32'h1);
        rdchk("R9 old", 5'd14, 32'd0);
        tkn(1);
        rdchk("R9 waiting", 5'd14, 32'd0);
        rdchk("R9 live", 5'd18, 32'd4);
        tkn(1);
        rdchk("R9 captured", 5'd14, 32'd5);
        tkn(1);
        rdchk("R9 held", 5'd14, 32'd5);
        rdchk("R9 live after", 5'd18, 32'd6);

        // R10 mode register
        wr(5'd3, 32'h5);
        rdchk("R10 mode", 5'd3, 32'h5);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule